// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Timer

This block makes three complementary pairs of center-aligned pulse-width-modulated signals for a three-phase inverter. A single up/down counter runs at the system clock rate. Each phase compares the counter against a threshold derived from that phase's duty value. A programmable dead time keeps the high and low switch of a leg from conducting together. Pulses that the dead time leaves too narrow are dropped rather than emitted.

Settings are presented on input ports, which act as the shadow copies. The block latches them into its working registers only at update points, so a change never cuts into a pulse already under way. Update points are the start of each period, plus the period midpoint when double-update mode is active. A sync pulse of programmable width marks each period start, together with a one-cycle interrupt strobe. A status flag tells whether the counter is in the first (rising) or second (falling) half of the period.

Top module: `tpwm_top`

## Requirements
- R1: With latched half-period value P, one switching period lasts 2·P clock cycles. `half_o` is 0 for the P cycles of the rising half and 1 for the P cycles of the falling half. A period value below 2 is treated as 2.
- R2: Let the counter value be v, which runs 0..P-1 rising, then P-1..0 falling. For a duty D with 0 < D < P, the high output of that phase is 1 while v ≥ P−D+T, where T is the latched dead time. This gives a centered pulse of 2·(D−T) cycles.
- R3: For 0 < D < P, the low output is 1 while v < P−D−T. It is centered on the period boundary, 2·(P−D−T) cycles wide, and never 1 in the same cycle as its high output.
- R4: A high pulse is deleted (output stays 0) when D−T ≤ 1. A low pulse is deleted when P−D−T ≤ 1. In both cases the adjusted width would be 2 cycles or fewer.
- R5: D = 0 holds the high output at 0 and the low output at 1 for the whole period. D ≥ P holds the high output at 1 and the low output at 0.
- R6: `sync_o` is 1 during the first S cycles of each rising half (v < S, where S is the latched sync width). `irq_o` is 1 for exactly one cycle per period, in the first cycle of the rising half.
- R7: With the latched mode bit at 0, all inputs (period, duties, dead time, sync width, mode) are latched only when the counter enters v = 0 of the rising half.
- R8: With the latched mode bit at 1, inputs are latched additionally when the counter turns from rising to falling. The falling half then runs for the new period value.
- R9: While `rst` is 1, all outputs become 0 at the next edge, the counter restarts at v = 0 rising, and all inputs are latched.
- R10: Every output is registered: it reflects the counter state and latched settings of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | 16 | Half-period length in clock cycles (shadow) |
| duty_a_i | input | 16 | Phase A duty value (shadow) |
| duty_b_i | input | 16 | Phase B duty value (shadow) |
| duty_c_i | input | 16 | Phase C duty value (shadow) |
| dead_i | input | 10 | Dead time in clock cycles (shadow) |
| sync_w_i | input | 8 | Sync pulse width in cycles (shadow) |
| dbl_upd_i | input | 1 | 1 = latch at start and midpoint, 0 = start only |
| hi_o | output | 3 | High-side outputs, bit 0 = A, 1 = B, 2 = C |
| lo_o | output | 3 | Low-side outputs, bit 0 = A, 1 = B, 2 = C |
| sync_o | output | 1 | Period-start sync pulse |
| irq_o | output | 1 | One-cycle interrupt strobe per period |
| half_o | output | 1 | 0 = rising half, 1 = falling half |

## Verification
Input changes take effect only at the next update point. The counter state built from them reaches the outputs one registered stage later. Reset clears the outputs at the first edge where it is sampled. The bench drives inputs on the falling edge and advances a behavioural model at each rising edge, using the same input values the design sees there. It then compares all outputs at the following falling edge, so every expectation sits at the cycle where the registered result is due. Fixed-length windows of exactly one period count pulse widths, which does not depend on where in the period the window starts.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } dir_e;

  localparam int unsigned MIN_PERIOD = 2;
endpackage

// File: rtl/tpwm_counter.sv
module tpwm_counter
  import tpwm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] per_act,
  input  logic [CW-1:0] per_nxt,
  input  logic          dbl,
  output logic [CW-1:0] cnt,
  output dir_e          dir,
  output logic          load
);
  logic at_top, at_bot;

  always_comb begin
    at_top = (dir == DIR_UP) && (cnt == per_act - CW'(1));
    at_bot = (dir == DIR_DN) && (cnt == '0);
    load   = (at_top && dbl) || at_bot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      dir <= DIR_UP;
    end else if (at_top) begin
      dir <= DIR_DN;
      if (dbl) cnt <= per_nxt - CW'(1);
    end else if (at_bot) begin
      dir <= DIR_UP;
    end else if (dir == DIR_UP) begin
      cnt <= cnt + CW'(1);
    end else begin
      cnt <= cnt - CW'(1);
    end
  end

  // R1: counter always stays inside the latched half period
  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
    cnt < per_act);

  // R1: leaving the top of the rising half always enters the falling half
  p_turn_down_r1: assert property (@(posedge clk) disable iff (rst)
    (dir == DIR_UP && cnt == per_act - CW'(1)) |=> (dir == DIR_DN));
endmodule

// File: rtl/tpwm_phase.sv
module tpwm_phase #(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] per,
  input  logic [CW-1:0] duty,
  input  logic [DW-1:0] dt,
  output logic          hi,
  output logic          lo
);
  localparam int unsigned XW = CW + 1;

  logic [XW-1:0] p_e, d_e, t_e, c_e, gap, thr_h, thr_l;
  logic          full_on, full_off, hi_ok, lo_ok, hi_n, lo_n;

  always_comb begin
    p_e      = {1'b0, per};
    d_e      = {1'b0, duty};
    t_e      = XW'(dt);
    c_e      = {1'b0, cnt};
    full_on  = d_e >= p_e;
    full_off = (duty == '0);
    gap      = p_e - d_e;
    thr_h    = gap + t_e;
    thr_l    = gap - t_e;
    hi_ok    = d_e > (t_e + XW'(1));
    lo_ok    = gap > (t_e + XW'(1));
    if (full_on) begin
      hi_n = 1'b1;
      lo_n = 1'b0;
    end else if (full_off) begin
      hi_n = 1'b0;
      lo_n = 1'b1;
    end else begin
      hi_n = hi_ok && (c_e >= thr_h);
      lo_n = lo_ok && (c_e < thr_l);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= 1'b0;
      lo <= 1'b0;
    end else begin
      hi <= hi_n;
      lo <= lo_n;
    end
  end

  // R3: the two switches of a leg are never on together
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    !(hi && lo));
endmodule

// File: rtl/tpwm_top.sv
module tpwm_top
  import tpwm_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 10,
  parameter int unsigned SW = 8,
  parameter int unsigned NPH = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [15:0]   period_i,
  input  logic [15:0]   duty_a_i,
  input  logic [15:0]   duty_b_i,
  input  logic [15:0]   duty_c_i,
  input  logic [9:0]    dead_i,
  input  logic [7:0]    sync_w_i,
  input  logic          dbl_upd_i,
  output logic [2:0]    hi_o,
  output logic [2:0]    lo_o,
  output logic          sync_o,
  output logic          irq_o,
  output logic          half_o
);
  logic [CW-1:0] per_q, per_in;
  logic [CW-1:0] duty_q [NPH];
  logic [CW-1:0] duty_in [NPH];
  logic [DW-1:0] dt_q;
  logic [SW-1:0] sw_q;
  logic          dbl_q;
  logic [CW-1:0] cnt;
  dir_e          dir;
  logic          load;

  always_comb begin
    per_in     = (CW'(period_i) < CW'(MIN_PERIOD)) ? CW'(MIN_PERIOD) : CW'(period_i);
    duty_in[0] = CW'(duty_a_i);
    duty_in[1] = CW'(duty_b_i);
    duty_in[2] = CW'(duty_c_i);
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      per_q <= per_in;
      dt_q  <= DW'(dead_i);
      sw_q  <= SW'(sync_w_i);
      dbl_q <= dbl_upd_i;
      for (int i = 0; i < NPH; i++) duty_q[i] <= duty_in[i];
    end
  end

  tpwm_counter #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .per_act (per_q),
    .per_nxt (per_in),
    .dbl     (dbl_q),
    .cnt     (cnt),
    .dir     (dir),
    .load    (load)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    tpwm_phase #(.CW(CW), .DW(DW)) u_ph (
      .clk  (clk),
      .rst  (rst),
      .cnt  (cnt),
      .per  (per_q),
      .duty (duty_q[g]),
      .dt   (dt_q),
      .hi   (hi_o[g]),
      .lo   (lo_o[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_o <= 1'b0;
      irq_o  <= 1'b0;
      half_o <= 1'b0;
    end else begin
      sync_o <= (dir == DIR_UP) && (cnt < CW'(sw_q));
      irq_o  <= (dir == DIR_UP) && (cnt == '0);
      half_o <= (dir == DIR_DN);
    end
  end

  // R9: reset quiets every output at the next edge
  p_rst_quiet_r9: assert property (@(posedge clk)
    rst |=> (hi_o == '0 && lo_o == '0 && !sync_o && !irq_o && !half_o));

  // R6: the strobe is raised only inside the rising half
  p_irq_first_half_r6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> !half_o);

  // R6: with a nonzero width the sync pulse covers the strobe cycle
  p_irq_has_sync_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_o && sw_q != '0) |-> sync_o);

  // R6: no two strobes in consecutive cycles
  p_irq_single_r6: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
endmodule

// File: tb/tpwm_top_tb_top.sv
module tpwm_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] period_i = 16'd10;
  logic [15:0] duty_a_i = 16'd5, duty_b_i = 16'd2, duty_c_i = 16'd12;
  logic [9:0]  dead_i = 10'd1;
  logic [7:0]  sync_w_i = 8'd3;
  logic        dbl_upd_i = 1'b0;
  logic [2:0]  hi_o, lo_o;
  logic        sync_o, irq_o, half_o;

  always #2 clk = ~clk;

  tpwm_top dut_i (
    .clk(clk), .rst(rst), .period_i(period_i),
    .duty_a_i(duty_a_i), .duty_b_i(duty_b_i), .duty_c_i(duty_c_i),
    .dead_i(dead_i), .sync_w_i(sync_w_i), .dbl_upd_i(dbl_upd_i),
    .hi_o(hi_o), .lo_o(lo_o), .sync_o(sync_o), .irq_o(irq_o), .half_o(half_o)
  );

  int total = 0, bad = 0;
  string ctx = "R9";

  // behavioural model state
  int mv, mdn, mP, mDT, mSW, mdbl;
  int mD[3];
  logic [2:0] eh, el;
  logic es, ei, ehalf;
  int n_hi[3], n_lo[3], n_sync, n_irq, n_half;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] act=%0d exp=%0d", tag, ctx, act, exp);
    end
  endtask

  task automatic m_load();
    mP = (period_i < 2) ? 2 : int'(period_i);
    mD[0] = duty_a_i; mD[1] = duty_b_i; mD[2] = duty_c_i;
    mDT = dead_i; mSW = sync_w_i; mdbl = dbl_upd_i;
  endtask

  function automatic bit f_hi(int v, int p, int d, int t);
    if (d >= p) return 1'b1;
    if (d == 0) return 1'b0;
    if (d - t <= 1) return 1'b0;
    return v >= p - d + t;
  endfunction

  function automatic bit f_lo(int v, int p, int d, int t);
    if (d >= p) return 1'b0;
    if (d == 0) return 1'b1;
    if (p - d - t <= 1) return 1'b0;
    return v < p - d - t;
  endfunction

  task automatic m_step();
    if (rst) begin
      mv = 0; mdn = 0; m_load();
      eh = '0; el = '0; es = 0; ei = 0; ehalf = 0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        eh[i] = f_hi(mv, mP, mD[i], mDT);
        el[i] = f_lo(mv, mP, mD[i], mDT);
      end
      es = (mdn == 0) && (mv < mSW);
      ei = (mdn == 0) && (mv == 0);
      ehalf = (mdn == 1);
      if (mdn == 0) begin
        if (mv == mP - 1) begin
          mdn = 1;
          if (mdbl != 0) begin m_load(); mv = mP - 1; end
        end else mv++;
      end else begin
        if (mv == 0) begin mdn = 0; m_load(); end
        else mv--;
      end
    end
  endtask

  // one clock: model advances at the rising edge, outputs compared at the falling edge
  task automatic tick();
    @(posedge clk);
    m_step();
    @(negedge clk);
    check(hi_o == eh, "R2", hi_o, eh);
    check(lo_o == el, "R3", lo_o, el);
    check(sync_o == es, "R6", sync_o, es);
    check(irq_o == ei, "R6", irq_o, ei);
    check(half_o == ehalf, "R1", half_o, ehalf);
    for (int i = 0; i < 3; i++) begin
      n_hi[i] += hi_o[i];
      n_lo[i] += lo_o[i];
    end
    n_sync += sync_o; n_irq += irq_o; n_half += half_o;
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic window(input int n);
    for (int i = 0; i < 3; i++) begin n_hi[i] = 0; n_lo[i] = 0; end
    n_sync = 0; n_irq = 0; n_half = 0;
    run(n);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog [%s] act=0 exp=1", ctx);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9: outputs idle under reset
    ctx = "R9 reset";
    run(3);
    check(hi_o == 3'b0 && lo_o == 3'b0, "R9", {hi_o, lo_o}, 0);
    check(!sync_o && !irq_o && !half_o, "R9", {sync_o, irq_o, half_o}, 0);
    @(negedge clk); rst = 1'b0;

    // P=10, T=1: A normal, B high deleted, C full on
    ctx = "R1 R2 R3 R4 R5 R6 R10 steady";
    run(20);
    window(20);
    check(n_hi[0] == 8, "R2", n_hi[0], 8);
    check(n_lo[0] == 8, "R3", n_lo[0], 8);
    check(n_hi[1] == 0, "R4", n_hi[1], 0);
    check(n_lo[1] == 14, "R3", n_lo[1], 14);
    check(n_hi[2] == 20 && n_lo[2] == 0, "R5", n_hi[2], 20);
    check(n_sync == 3, "R6", n_sync, 3);
    check(n_irq == 1, "R6", n_irq, 1);
    check(n_half == 10, "R1", n_half, 10);

    // single mode: change mid-period, takes effect only at next start
    ctx = "R7 single-mode latch";
    run(13);
    duty_a_i = 16'd0; duty_c_i = 16'd7; dead_i = 10'd2;
    run(27);
    window(20);
    check(n_hi[0] == 0 && n_lo[0] == 20, "R5", n_lo[0], 20);
    check(n_hi[2] == 10, "R7", n_hi[2], 10);

    // period below the minimum is clamped to 2
    ctx = "R1 period clamp";
    period_i = 16'd1; sync_w_i = 8'd1;
    run(40);
    window(20);
    check(n_half == 10, "R1", n_half, 10);
    check(n_irq == 5, "R1", n_irq, 5);

    // double mode with low-side deletion and a period change mid-run
    ctx = "R8 double-mode latch";
    period_i = 16'd10; dbl_upd_i = 1'b1;
    duty_a_i = 16'd3; duty_b_i = 16'd8; duty_c_i = 16'd5; dead_i = 10'd1;
    run(40);
    window(20);
    check(n_lo[1] == 0, "R4", n_lo[1], 0);
    check(n_hi[0] == 4, "R8", n_hi[0], 4);
    run(7);
    duty_a_i = 16'd6; period_i = 16'd12;
    run(60);
    window(24);
    check(n_hi[0] == 10, "R8", n_hi[0], 10);

    // reset in the middle of a run
    ctx = "R9 mid-run reset";
    run(5);
    rst = 1'b1;
    run(1);
    check(hi_o == 3'b0 && lo_o == 3'b0 && !half_o, "R9", {hi_o, lo_o}, 0);
    @(negedge clk); rst = 1'b0;
    ctx = "R10 after reset";
    run(50);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule